// File: doc/BRIEF.md
# Prioritised Interrupt Controller Register Bank

This block holds the per-line interrupt state for up to 64 external interrupt lines and picks the line a processor core should take next. Each line has an enable bit, a pending bit, an active bit and a 4-bit priority level. Software reaches all of this through a small word-addressed register bus that has a write strobe, a read strobe and combinational read data. Enable and pending state change only through paired set and clear registers, where each bit written as one acts and each bit written as zero is ignored. Hardware request inputs and a software-trigger register also make lines pending.

The core drives a two-strobe service handshake. An acknowledge takes the presented line from pending to active. An end-of-service strobe, which carries a line number, retires that line. A grouping register splits each priority level into a preemption part and a sub-priority part. A new line is presented while another is active only if its preemption part is strictly lower than the lowest preemption part among the active lines.

Top module: `icx_ctrl`

## Requirements
- R1: After reset every enable, pending and active bit, every priority level and the grouping field are zero, and irq_valid is low.
- R2: Line n maps to bit n%32 of word n/32. A write to set-enable (word addresses 0 and 1) sets the enable bits written as one. A write to clear-enable (addresses 2 and 3) clears them. Bits written as zero have no effect. Both address pairs read back the current enable bits.
- R3: Set-pending (addresses 4 and 5) and clear-pending (addresses 6 and 7) work on pending bits in the same way, and both pairs read the pending bits. Setting a line that is already pending leaves it pending and changes nothing else.
- R4: A clear-pending bit written as one has no effect on a line whose active bit is set.
- R5: A line whose irq_req input is high at a clock edge is pending after that edge.
- R6: Addresses 16 to 31 hold one priority byte per line: line n is byte n%4 of word 16+n/4, with the byte at bits [8*(n%4)+7 : 8*(n%4)]. Only the upper four bits of each byte are stored. The lower four bits read as zero.
- R7: A write of value v to the software-trigger register (address 10) makes line v pending when v is at most 239 and names an existing line. Any other value changes no state.
- R8: irq_id and irq_prio name the enabled pending line with the lowest priority level. A tie goes to the lower line number. irq_valid is never high without such a line.
- R9: svc_ack while irq_valid is high clears the presented line's pending bit and sets its active bit at the next edge. svc_ack while irq_valid is low has no effect.
- R10: svc_eos clears the active bit of line svc_eos_id at the next edge.
- R11: The grouping field g (address 11, bits [2:0], read back) sets the preemption part of a level to its upper 4 bits when g<=3, 3 bits when g=4, 2 bits when g=5, 1 bit when g=6, and no bits when g=7. irq_valid is high only when no line is active, or when the chosen line's preemption part is strictly below the lowest preemption part among the active lines.
- R12: The active register (addresses 8 and 9) is read-only. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| irq_req | input | 64 | Hardware interrupt requests, sampled each edge |
| svc_ack | input | 1 | Core takes the presented line |
| svc_eos | input | 1 | Core finishes servicing line svc_eos_id |
| svc_eos_id | input | 6 | Line number being retired |
| irq_valid | output | 1 | A line is presented to the core |
| irq_id | output | 6 | Number of the presented line |
| irq_prio | output | 4 | Priority level of the presented line |

## Verification
The hardest situation to reach from the ports is nesting: a line must already be active while a second enabled line of equal or lower level is pending, and the grouping field then has to change underneath both of them. The stimulus builds this step by step. It acknowledges a line, pends competitors of equal, lower and higher level, and then rewrites the grouping field through all the cases where the preemption comparison changes outcome. A behavioural model is compared with the outputs on every clock throughout.

// File: rtl/icx_pkg.sv
package icx_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int LVL_W  = 4;

    localparam logic [ADDR_W-1:0] A_ENSET  = 6'd0;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 6'd2;
    localparam logic [ADDR_W-1:0] A_PDSET  = 6'd4;
    localparam logic [ADDR_W-1:0] A_PDCLR  = 6'd6;
    localparam logic [ADDR_W-1:0] A_ACT    = 6'd8;
    localparam logic [ADDR_W-1:0] A_SWTRIG = 6'd10;
    localparam logic [ADDR_W-1:0] A_GROUP  = 6'd11;
    localparam logic [ADDR_W-1:0] A_PRIO   = 6'd16;

    localparam int SW_MAX = 239;

    // Bits of a level that take part in preemption for a grouping value
    function automatic logic [LVL_W-1:0] preempt_mask(input logic [2:0] grp);
        logic [LVL_W-1:0] m;
        unique case (grp)
            3'd4:    m = 4'hE;
            3'd5:    m = 4'hC;
            3'd6:    m = 4'h8;
            3'd7:    m = 4'h0;
            default: m = 4'hF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/icx_select.sv
module icx_select
    import icx_pkg::*;
#(
    parameter int N   = 64,
    parameter int IDW = 6
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][LVL_W-1:0] lvl,
    output logic                    found,
    output logic [IDW-1:0]          win_id,
    output logic [LVL_W-1:0]        win_lvl
);
    // Strict less-than keeps the lowest line number on ties
    always_comb begin
        found   = 1'b0;
        win_id  = '0;
        win_lvl = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || lvl[i] < win_lvl)) begin
                found   = 1'b1;
                win_id  = IDW'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/icx_run_level.sv
module icx_run_level
    import icx_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]            act,
    input  logic [N-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]        mask,
    output logic                    any_act,
    output logic [LVL_W-1:0]        run_lvl
);
    always_comb begin
        any_act = |act;
        run_lvl = '1;
        for (int i = 0; i < N; i++) begin
            if (act[i] && ((lvl[i] & mask) < run_lvl))
                run_lvl = lvl[i] & mask;
        end
    end
endmodule

// File: rtl/icx_ctrl.sv
module icx_ctrl
    import icx_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [5:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_IRQ-1:0]         irq_req,
    input  logic                       svc_ack,
    input  logic                       svc_eos,
    input  logic [$clog2(NUM_IRQ)-1:0] svc_eos_id,
    output logic                       irq_valid,
    output logic [$clog2(NUM_IRQ)-1:0] irq_id,
    output logic [3:0]                 irq_prio
);
    localparam int IDW    = $clog2(NUM_IRQ);
    localparam int NWORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
    localparam int PADW   = NWORDS * DATA_W;
    localparam int PWORDS = (NUM_IRQ + 3) / 4;

    logic [NUM_IRQ-1:0]            en_q, pend_q, act_q;
    logic [NUM_IRQ-1:0][LVL_W-1:0] prio_q;
    logic [2:0]                    grp_q;

    logic [NUM_IRQ-1:0] en_set_m, en_clr_m, pd_set_m, pd_clr_m, sw_m;
    logic [NUM_IRQ-1:0] ack_m, eos_m, prio_we;
    logic [NUM_IRQ-1:0][LVL_W-1:0] prio_wv;

    logic             found, any_act, ack_fire;
    logic [IDW-1:0]   win_id;
    logic [LVL_W-1:0] win_lvl, run_lvl, pmask;

    assign ack_fire = svc_ack && irq_valid;
    assign pmask    = preempt_mask(grp_q);

    // Per-line write decode
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int WI = i / DATA_W;
        localparam int BI = i % DATA_W;
        localparam int PW = i / 4;
        localparam int PB = (i % 4) * 8 + 4;
        assign en_set_m[i] = bus_wr && bus_addr == A_ENSET + 6'(WI) && bus_wdata[BI];
        assign en_clr_m[i] = bus_wr && bus_addr == A_ENCLR + 6'(WI) && bus_wdata[BI];
        assign pd_set_m[i] = bus_wr && bus_addr == A_PDSET + 6'(WI) && bus_wdata[BI];
        assign pd_clr_m[i] = bus_wr && bus_addr == A_PDCLR + 6'(WI) && bus_wdata[BI];
        assign sw_m[i]     = bus_wr && bus_addr == A_SWTRIG && i <= SW_MAX
                             && bus_wdata == 32'(i);
        assign prio_we[i]  = bus_wr && bus_addr == A_PRIO + 6'(PW);
        assign prio_wv[i]  = bus_wdata[PB +: LVL_W];
        assign ack_m[i]    = ack_fire && irq_id == IDW'(i);
        assign eos_m[i]    = svc_eos && svc_eos_id == IDW'(i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            prio_q <= '0;
            grp_q  <= '0;
        end else begin
            en_q   <= (en_q | en_set_m) & ~en_clr_m;
            pend_q <= (pend_q & ~(pd_clr_m & ~act_q) & ~ack_m)
                      | pd_set_m | irq_req | sw_m;
            act_q  <= (act_q & ~eos_m) | ack_m;
            for (int i = 0; i < NUM_IRQ; i++)
                if (prio_we[i]) prio_q[i] <= prio_wv[i];
            if (bus_wr && bus_addr == A_GROUP)
                grp_q <= bus_wdata[2:0];
        end
    end

    icx_select #(.N(NUM_IRQ), .IDW(IDW)) u_select (
        .cand    (en_q & pend_q),
        .lvl     (prio_q),
        .found   (found),
        .win_id  (win_id),
        .win_lvl (win_lvl)
    );

    icx_run_level #(.N(NUM_IRQ)) u_run_level (
        .act     (act_q),
        .lvl     (prio_q),
        .mask    (pmask),
        .any_act (any_act),
        .run_lvl (run_lvl)
    );

    assign irq_valid = found && (!any_act || ((win_lvl & pmask) < run_lvl));
    assign irq_id    = win_id;
    assign irq_prio  = win_lvl;

    // Read mux
    logic [PADW-1:0] en_pad, pend_pad, act_pad;
    assign en_pad   = PADW'(en_q);
    assign pend_pad = PADW'(pend_q);
    assign act_pad  = PADW'(act_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (bus_addr == A_ENSET + 6'(w) || bus_addr == A_ENCLR + 6'(w))
                    bus_rdata = en_pad[w*DATA_W +: DATA_W];
                if (bus_addr == A_PDSET + 6'(w) || bus_addr == A_PDCLR + 6'(w))
                    bus_rdata = pend_pad[w*DATA_W +: DATA_W];
                if (bus_addr == A_ACT + 6'(w))
                    bus_rdata = act_pad[w*DATA_W +: DATA_W];
            end
            if (bus_addr == A_GROUP)
                bus_rdata = {29'd0, grp_q};
            for (int k = 0; k < PWORDS; k++) begin
                if (bus_addr == A_PRIO + 6'(k)) begin
                    for (int j = 0; j < 4; j++)
                        if (k * 4 + j < NUM_IRQ)
                            bus_rdata[j*8+4 +: LVL_W] = prio_q[k*4+j];
                end
            end
        end
    end
endmodule

// File: rtl/icx_ctrl_chk.sv
module icx_ctrl_chk #(
    parameter int N   = 64,
    parameter int IDW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [5:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [31:0]    bus_rdata,
    input logic           svc_ack,
    input logic           svc_eos,
    input logic [IDW-1:0] svc_eos_id,
    input logic           irq_valid,
    input logic [IDW-1:0] irq_id,
    input logic [N-1:0]   en_q,
    input logic [N-1:0]   pend_q,
    input logic [N-1:0]   act_q
);
    p_valid_has_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (en_q[irq_id] && pend_q[irq_id]));

    p_no_line_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & pend_q) == '0) |-> !irq_valid);

    p_ack_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && irq_valid && !(svc_eos && svc_eos_id == irq_id))
        |=> act_q[$past(irq_id)]);

    p_eos_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_eos && !(svc_ack && irq_valid && irq_id == svc_eos_id))
        |=> !act_q[$past(svc_eos_id)]);

    p_set_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'd4 && bus_wdata[0]) |=> pend_q[0]);

    p_low_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= 6'd16 && bus_addr < 6'd32)
        |-> ((bus_rdata & 32'h0F0F_0F0F) == 32'd0));

    p_active_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 6'd8 || bus_addr == 6'd9) && !svc_eos
         && !(svc_ack && irq_valid)) |=> $stable(act_q));
endmodule

bind icx_ctrl icx_ctrl_chk #(.N(NUM_IRQ), .IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .svc_ack    (svc_ack),
    .svc_eos    (svc_eos),
    .svc_eos_id (svc_eos_id),
    .irq_valid  (irq_valid),
    .irq_id     (irq_id),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .act_q      (act_q)
);

// File: tb/icx_ctrl_bench.sv
module icx_ctrl_bench;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [31:0] b_rdata;
    logic [N-1:0] req = '0;
    logic        ack = 1'b0, eos = 1'b0;
    logic [5:0]  eos_id = '0;
    logic        irq_valid;
    logic [5:0]  irq_id;
    logic [3:0]  irq_prio;

    int checks = 0, fails = 0;
    bit done = 0;

    // Behavioural model state
    int m_en[N], m_pd[N], m_ac[N], m_pr[N];
    int m_grp;

    always #5 clk = ~clk;

    icx_ctrl u_icx_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wd),
        .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(b_rdata), .irq_req(req),
        .svc_ack(ack), .svc_eos(eos), .svc_eos_id(eos_id),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_pr[i] = 0;
        end
        m_grp = 0;
    endtask

    function automatic int shift_of();
        return (m_grp > 3) ? m_grp - 3 : 0;
    endfunction

    // Preempt part compared by shifting away sub-priority bits
    task automatic model_pick(output int v, output int id, output int pr);
        int best = -1, runl = 1000, anyac = 0, sh = shift_of();
        for (int i = 0; i < N; i++) begin
            if (m_en[i] != 0 && m_pd[i] != 0 && (best < 0 || m_pr[i] < m_pr[best]))
                best = i;
            if (m_ac[i] != 0) begin
                anyac = 1;
                if (sh < 4 && (m_pr[i] >> sh) < runl) runl = m_pr[i] >> sh;
                if (sh >= 4) runl = 0;
            end
        end
        id = (best < 0) ? 0 : best;
        pr = (best < 0) ? 15 : m_pr[best];
        if (best < 0) v = 0;
        else if (anyac == 0) v = 1;
        else if (sh >= 4) v = 0;
        else v = ((m_pr[best] >> sh) < runl) ? 1 : 0;
    endtask

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] r = '0;
        if (a <= 9) begin
            for (int b = 0; b < 32; b++) begin
                int i = (a % 2) * 32 + b;
                if (a <= 3) r[b] = (m_en[i] != 0);
                else if (a <= 7) r[b] = (m_pd[i] != 0);
                else r[b] = (m_ac[i] != 0);
            end
        end else if (a == 11) begin
            r = 32'(m_grp);
        end else if (a >= 16 && a < 32) begin
            for (int j = 0; j < 4; j++)
                r[j*8+4 +: 4] = 4'(m_pr[(a - 16) * 4 + j]);
        end
        return r;
    endfunction

    task automatic model_update(input int mv, input int mid);
        int a = int'(b_addr);
        for (int i = 0; i < N; i++) begin
            int w = i / 32, b = i % 32;
            int setp = 0, clrp = 0;
            if (b_wr && b_wd[b]) begin
                if (a == w) m_en[i] = 1;
                if (a == 2 + w) m_en[i] = 0;
                if (a == 4 + w) setp = 1;
                if (a == 6 + w) clrp = 1;
            end
            if (b_wr && a == 10 && b_wd <= 239 && b_wd == 32'(i)) setp = 1;
            if (req[i]) setp = 1;
            if (clrp && m_ac[i] == 0) m_pd[i] = 0;
            if (ack && mv != 0 && mid == i) m_pd[i] = 0;
            if (setp) m_pd[i] = 1;
            if (eos && int'(eos_id) == i) m_ac[i] = 0;
            if (ack && mv != 0 && mid == i) m_ac[i] = 1;
        end
        if (b_wr && a == 11) m_grp = int'(b_wd[2:0]);
        if (b_wr && a >= 16 && a < 32)
            for (int j = 0; j < 4; j++)
                m_pr[(a - 16) * 4 + j] = int'(b_wd[j*8+4 +: 4]);
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act_v,
                         input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
        end
    endtask

    // One clock: inputs already driven after a falling edge
    task automatic cyc(input string tag);
        int mv, mid, mpr;
        #1;
        model_pick(mv, mid, mpr);
        check(tag, "irq_valid", 32'(irq_valid), 32'(mv));
        if (mv != 0) begin
            check(tag, "irq_id", 32'(irq_id), 32'(mid));
            check(tag, "irq_prio", 32'(irq_prio), 32'(mpr));
        end
        if (b_rd) check(tag, "rdata", b_rdata, model_read(int'(b_addr)));
        @(posedge clk);
        model_update(mv, mid);
        @(negedge clk);
        b_wr = 0; b_rd = 0; ack = 0; eos = 0; req = '0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        b_addr = 6'(a); b_wd = d; b_wr = 1; cyc(tag);
    endtask
    task automatic rd(input int a, input string tag);
        b_addr = 6'(a); b_rd = 1; cyc(tag);
    endtask
    task automatic do_ack(input string tag);
        ack = 1; cyc(tag);
    endtask
    task automatic do_eos(input int id, input string tag);
        eos = 1; eos_id = 6'(id); cyc(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 32; a++) rd(a, "R1");

        // R2 enables: set, zero-write, clear, both read addresses, word 1 mapping
        wr(0, 32'h5, "R2"); rd(0, "R2"); rd(2, "R2");
        wr(0, 32'h0, "R2"); rd(0, "R2");
        wr(1, 32'h8, "R2"); rd(1, "R2"); rd(3, "R2");
        wr(2, 32'h1, "R2"); rd(0, "R2"); rd(2, "R2");

        // R6 priority bytes keep upper nibble only
        wr(16, 32'hFFA5_3C7E, "R6"); rd(16, "R6");
        wr(31, 32'h1234_5678, "R6"); rd(31, "R6");

        // R3 pending set twice, read both addresses, clear
        wr(4, 32'h8000_0000, "R3"); wr(4, 32'h8000_0000, "R3");
        rd(4, "R3"); rd(6, "R3");
        wr(6, 32'h8000_0000, "R3"); rd(4, "R3");

        // R5 hardware request on line 40
        req[40] = 1'b1; cyc("R5"); rd(5, "R5"); rd(7, "R5");

        // R8 arbitration setup
        wr(6, 32'hFFFF_FFFF, "R8"); wr(7, 32'hFFFF_FFFF, "R8");
        for (int k = 16; k < 32; k++) wr(k, 32'hF0F0_F0F0, "R8");
        wr(0, 32'hFFFF_FFFF, "R8"); wr(1, 32'hFFFF_FFFF, "R8");
        wr(18, 32'hF0F0_50F0, "R8");   // line 9 level 5
        wr(19, 32'hF0F0_F050, "R8");   // line 12 level 5
        wr(4, (32'h1 << 12) | (32'h1 << 9), "R8");
        cyc("R8");                     // tie -> line 9
        wr(28, 32'hF020_F0F0, "R8");   // line 50 level 2
        wr(5, 32'h1 << 18, "R8");
        cyc("R8");                     // line 50 wins

        // R9 acknowledge, then ack with nothing presented
        do_ack("R9"); rd(9, "R9"); rd(5, "R9");
        cyc("R11");                    // 9 not presented under active 50
        do_ack("R9"); rd(8, "R9"); rd(9, "R9");

        // R10 end of service
        do_eos(50, "R10"); rd(9, "R10");
        do_ack("R9");                  // line 9 active
        cyc("R11");                    // line 12 equal level: held
        wr(26, 32'hF0F0_F030, "R11");  // line 40 level 3
        wr(5, 32'h1 << 8, "R11"); cyc("R11");

        // R11 grouping variants
        wr(11, 32'h6, "R11"); cyc("R11");
        wr(11, 32'h7, "R11"); cyc("R11");
        wr(11, 32'h4, "R11"); cyc("R11");
        wr(11, 32'h5, "R11"); rd(11, "R11");
        wr(11, 32'h0, "R11");

        // R4 clear-pending ignored on active line 9
        wr(4, 32'h1 << 9, "R4"); rd(4, "R4");
        wr(6, (32'h1 << 9) | (32'h1 << 12), "R4"); rd(4, "R4");

        // R12 active register read-only
        wr(8, 32'h0, "R12"); wr(9, 32'hFFFF_FFFF, "R12");
        rd(8, "R12"); rd(9, "R12");

        // R7 software trigger
        wr(6, 32'hFFFF_FFFF, "R7"); wr(7, 32'hFFFF_FFFF, "R7");
        wr(10, 32'd240, "R7"); wr(10, 32'd1000, "R7"); wr(10, 32'd239, "R7");
        rd(4, "R7"); rd(5, "R7");
        wr(10, 32'd3, "R7"); wr(10, 32'd63, "R7");
        rd(4, "R7"); rd(5, "R7");

        do_eos(9, "R10"); rd(8, "R10");
        cyc("R8"); do_ack("R9"); cyc("R8");
        finish_run();
    end
endmodule